// File: doc/BRIEF.md
# Interval Timer with Snapshot Capture

This block is a 32-bit down-counting interval timer on a word-addressed register bus. It drives one level interrupt. Software writes the period as two 16-bit halves. It starts and stops the count with command bits in the control register and picks either one-shot or continuous mode. To read the live count safely, software writes to a snapshot register, which copies the full count into two 16-bit read-only halves in a single cycle.

When the counter is running and reaches zero, it raises a sticky timeout flag and reloads from the period, so one interval lasts period + 1 clock cycles. In continuous mode the count carries on. In one-shot mode the timer stops and holds the period value. The interrupt is the timeout flag gated by an enable bit. Software clears the flag by writing to the status register.

Top module: `interval_timer`

## Requirements
- R1: The word index is byte address bits [4:2]. Index 0 is status, 1 is control, 2 is period low, 3 is period high, 4 is snapshot low and 5 is snapshot high. Indexes 6 and 7 read as zero and ignore writes. Address bits [1:0] are ignored.
- R2: After reset, every register reads zero, the timer is stopped, the counter holds all ones and the interrupt is low.
- R3: Status bit 0 is the sticky timeout flag and bit 1 is the running flag. Any write to status clears bit 0 and leaves bit 1 unchanged. If a timeout falls in the same cycle as the status write, the flag stays set.
- R4: Control bit 0 (interrupt enable) and bit 1 (continuous mode) are stored and read back. Bits 2 and 3 are commands and always read as zero.
- R5: A control write with bit 2 (start) set starts a stopped timer. A write with bit 3 (stop) set stops it. If both bits are set, the timer ends up stopped. Start on a running timer has no effect. A stopped counter holds its value.
- R6: Each period register keeps only data bits [15:0]. Writing either period register stops the timer and loads the counter with {period high, period low}.
- R7: While the timer runs, the counter decreases by one per cycle. An interval from a start to the timeout lasts period + 1 cycles.
- R8: When the running counter is zero, the timeout flag sets and the counter reloads the period. In continuous mode the timer keeps running. Otherwise it stops and holds the period value.
- R9: A write of any data to index 4 or 5 copies the current count: bits [15:0] go into snapshot low and bits [31:16] into snapshot high.
- R10: The interrupt output equals timeout flag AND interrupt enable. It stays high until the flag is cleared or the enable is removed.
- R11: Read data is combinational from the current address. A write takes effect on the clock edge that samples it, so a read of the same index in that cycle still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Level interrupt |

## Verification
The two functions that can collide are the counter's own timeout and a software register write in the same cycle. The collisions are a status write against the flag being set, and a period or control write against the reload and the run-state change. A directed case steps the timer to the zero count and issues the status write on exactly that cycle. Long random runs use short periods, so that timeouts often coincide with stop, start, period and snapshot writes. A cycle-stepped reference in the bench, derived from the requirements, judges every read and interrupt value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_REGS = 6;

  typedef enum logic [2:0] {
    IDX_STATUS  = 3'd0,
    IDX_CTRL    = 3'd1,
    IDX_PER_LO  = 3'd2,
    IDX_PER_HI  = 3'd3,
    IDX_SNAP_LO = 3'd4,
    IDX_SNAP_HI = 3'd5
  } reg_idx_e;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_RUN     = 1;

  localparam int CTL_IE     = 0;
  localparam int CTL_CONT   = 1;
  localparam int CTL_START  = 2;
  localparam int CTL_STOP   = 3;
endpackage

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign timeout_o = run_q && (cnt_q == '0);

  always_comb begin
    if (stop_i || load_i)             run_d = 1'b0;
    else if (start_i && !run_q)       run_d = 1'b1;
    else if (timeout_o && !cont_i)    run_d = 1'b0;
    else                              run_d = run_q;
  end

  always_comb begin
    if (load_i || timeout_o) cnt_d = period_i;
    else if (run_q)          cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '1;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;

  a_r6_load_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!run_q && cnt_q == $past(period_i)));
  a_r5_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);
  a_r5_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !load_i && !run_q) |=> run_q);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> (cnt_q == $past(cnt_q)));
  a_r7_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r8_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !cont_i) |=> (!run_q && cnt_q == $past(period_i)));
  a_r8_continuous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && cont_i && !stop_i && !load_i) |=> (run_q && cnt_q == $past(period_i)));
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * HALF_W,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              timeout_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              load_o,
  output logic              cont_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              flag_o,
  output logic              ie_o
);
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr;
  logic                to_q, ie_q, cont_q;
  logic [HALF_W-1:0]   per_lo_q, per_hi_q, snap_lo_q, snap_hi_q;
  logic                snap_wr;

  assign idx = addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign wr[k] = we_i && (idx == IDX_W'(k));
  end

  assign snap_wr = wr[IDX_SNAP_LO] || wr[IDX_SNAP_HI];
  assign start_o = wr[IDX_CTRL] && wdata_i[CTL_START];
  assign stop_o  = wr[IDX_CTRL] && wdata_i[CTL_STOP];
  assign load_o  = wr[IDX_PER_LO] || wr[IDX_PER_HI];

  // New period is visible to the core in the cycle of the write
  always_comb begin
    if (wr[IDX_PER_LO])      period_o = {per_hi_q, wdata_i[HALF_W-1:0]};
    else if (wr[IDX_PER_HI]) period_o = {wdata_i[HALF_W-1:0], per_lo_q};
    else                     period_o = {per_hi_q, per_lo_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q      <= 1'b0;
      ie_q      <= 1'b0;
      cont_q    <= 1'b0;
      per_lo_q  <= '0;
      per_hi_q  <= '0;
      snap_lo_q <= '0;
      snap_hi_q <= '0;
    end else begin
      // timeout beats a simultaneous clear
      if (timeout_i)               to_q <= 1'b1;
      else if (wr[IDX_STATUS])     to_q <= 1'b0;
      if (wr[IDX_CTRL]) begin
        ie_q   <= wdata_i[CTL_IE];
        cont_q <= wdata_i[CTL_CONT];
      end
      if (wr[IDX_PER_LO]) per_lo_q <= wdata_i[HALF_W-1:0];
      if (wr[IDX_PER_HI]) per_hi_q <= wdata_i[HALF_W-1:0];
      if (snap_wr) begin
        snap_lo_q <= cnt_i[HALF_W-1:0];
        snap_hi_q <= cnt_i[CNT_W-1:HALF_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_W'(IDX_STATUS): begin
        rdata_o[ST_TIMEOUT] = to_q;
        rdata_o[ST_RUN]     = run_i;
      end
      IDX_W'(IDX_CTRL): begin
        rdata_o[CTL_IE]   = ie_q;
        rdata_o[CTL_CONT] = cont_q;
      end
      IDX_W'(IDX_PER_LO):  rdata_o[HALF_W-1:0] = per_lo_q;
      IDX_W'(IDX_PER_HI):  rdata_o[HALF_W-1:0] = per_hi_q;
      IDX_W'(IDX_SNAP_LO): rdata_o[HALF_W-1:0] = snap_lo_q;
      IDX_W'(IDX_SNAP_HI): rdata_o[HALF_W-1:0] = snap_hi_q;
      default:             rdata_o = '0;
    endcase
  end

  assign cont_o = cont_q;
  assign flag_o = to_q;
  assign ie_o   = ie_q;

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:HALF_W]};

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr[IDX_STATUS] && !timeout_i) |=> !to_q);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> to_q);
  a_r4_ctrl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr[IDX_CTRL] |=> (ie_q == $past(wdata_i[CTL_IE]) && cont_q == $past(wdata_i[CTL_CONT])));
  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_wr |=> ({snap_hi_q, snap_lo_q} == $past(cnt_i)));
  a_r1_unused_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx >= IDX_W'(NUM_REGS)) |=>
      $stable({ie_q, cont_q, per_lo_q, per_hi_q, snap_lo_q, snap_hi_q}));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int IDX_W = ADDR_W - 2;

  logic             start, stop, load, cont, run, timeout, flag, ie;
  logic [CNT_W-1:0] period, cnt;

  timer_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .run_i     (run),
    .cnt_i     (cnt),
    .timeout_i (timeout),
    .start_o   (start),
    .stop_o    (stop),
    .load_o    (load),
    .cont_o    (cont),
    .period_o  (period),
    .flag_o    (flag),
    .ie_o      (ie)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .load_i    (load),
    .cont_i    (cont),
    .period_i  (period),
    .run_o     (run),
    .cnt_o     (cnt),
    .timeout_o (timeout)
  );

  assign irq_o = flag && ie;

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr_i[ADDR_W-1:2];

  // R10: level holds unless software touches status or control
  a_r10_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(bus_we_i && (idx == IDX_W'(IDX_STATUS) || idx == IDX_W'(IDX_CTRL))))
      |=> irq_o);
  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ie);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_vec = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // reference state
  logic        m_to = 0, m_run = 0, m_ie = 0, m_cont = 0;
  logic [15:0] m_plo = 0, m_phi = 0, m_slo = 0, m_shi = 0;
  logic [31:0] m_cnt = 32'hFFFF_FFFF;
  logic        n_to, n_run, n_ie, n_cont;
  logic [15:0] n_plo, n_phi, n_slo, n_shi;
  logic [31:0] n_cnt;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a[4:2])
      3'd0:    return {30'b0, m_run, m_to};
      3'd1:    return {30'b0, m_cont, m_ie};
      3'd2:    return {16'b0, m_plo};
      3'd3:    return {16'b0, m_phi};
      3'd4:    return {16'b0, m_slo};
      3'd5:    return {16'b0, m_shi};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a[4:2])
      3'd0:       return "R3";
      3'd1:       return "R4";
      3'd2, 3'd3: return "R6";
      3'd4, 3'd5: return "R9";
      default:    return "R1";
    endcase
  endfunction

  task m_step(input logic w, input logic [4:0] a, input logic [31:0] d);
    logic tmo;
    tmo = m_run && (m_cnt == 32'd0);
    n_to = m_to; n_run = m_run; n_ie = m_ie; n_cont = m_cont;
    n_plo = m_plo; n_phi = m_phi; n_slo = m_slo; n_shi = m_shi; n_cnt = m_cnt;
    if (m_run) begin
      if (tmo) begin
        n_to = 1'b1;
        n_cnt = {m_phi, m_plo};
        if (!m_cont) n_run = 1'b0;
      end else n_cnt = m_cnt - 1;
    end
    if (w) begin
      case (a[4:2])
        3'd0: if (!tmo) n_to = 1'b0;
        3'd1: begin
          n_ie = d[0]; n_cont = d[1];
          if (d[2] && !m_run) n_run = 1'b1;
          if (d[3]) n_run = 1'b0;
        end
        3'd2: begin n_plo = d[15:0]; n_run = 1'b0; n_cnt = {m_phi, d[15:0]}; end
        3'd3: begin n_phi = d[15:0]; n_run = 1'b0; n_cnt = {d[15:0], m_plo}; end
        3'd4, 3'd5: begin n_slo = m_cnt[15:0]; n_shi = m_cnt[31:16]; end
        default: ;
      endcase
    end
  endtask

  task m_commit();
    m_to = n_to; m_run = n_run; m_ie = n_ie; m_cont = n_cont;
    m_plo = n_plo; m_phi = n_phi; m_slo = n_slo; m_shi = n_shi; m_cnt = n_cnt;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                     input string req);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
    chk(rdata, m_read(a), (req == "") ? tag_of(a) : req, "rdata");
    chk({31'b0, irq}, {31'b0, m_to && m_ie}, "R10", "irq");
    m_step(w, a, d);
    @(posedge clk);
    m_commit();
  endtask

  task automatic rd(input int idx, input string req);
    cyc(1'b0, 5'(idx << 2), 32'h0, req);
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string req);
    cyc(1'b1, 5'(idx << 2), d, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset state; snapshot shows the all-ones counter
    for (int i = 0; i < 8; i++) rd(i, "R2");
    wr(4, 32'h0, "R2");
    rd(4, "R2"); rd(5, "R2");

    // R6 masking and load, R11 write timing
    wr(2, 32'hABCD_0005, "R6");
    wr(3, 32'h1234_0000, "R6");
    rd(2, "R6"); rd(3, "R6");
    wr(1, 32'h0000_0001, "R11");
    rd(1, "R11");

    // R5/R7/R8 one-shot run with interrupt
    wr(1, 32'h0000_0005, "R5");
    for (int i = 0; i < 4; i++) rd(0, "R7");
    wr(4, 32'h0, "R9");
    rd(4, "R9");
    rd(0, "R8"); rd(0, "R8"); rd(4, "R8");
    wr(5, 32'hFFFF_FFFF, "R8");
    rd(4, "R8"); rd(1, "R10");
    wr(1, 32'h0000_0000, "R10");
    rd(0, "R10");
    wr(1, 32'h0000_0001, "R10");
    wr(0, 32'h0, "R3");
    rd(0, "R3");

    // R3 clear colliding with a timeout
    wr(1, 32'h0000_0007, "R5");
    for (int i = 0; i < 20 && !(m_run && m_cnt == 0); i++) rd(0, "R7");
    wr(0, 32'h0, "R3");
    rd(0, "R3");
    wr(0, 32'h0, "R3");
    rd(0, "R3");

    // R5 start on running, start+stop, stop
    wr(1, 32'h0000_0007, "R5");
    rd(0, "R5");
    wr(1, 32'h0000_000E, "R5");
    rd(0, "R5");
    wr(1, 32'h0000_0004, "R5");
    wr(1, 32'h0000_0008, "R5");
    rd(0, "R5"); wr(4, 0, "R5"); rd(4, "R5"); rd(4, "R5");

    // R1 unused offsets and low address bits
    wr(6, 32'hFFFF_FFFF, "R1");
    wr(7, 32'hFFFF_FFFF, "R1");
    cyc(1'b0, 5'b00111, 32'h0, "R1");
    for (int i = 0; i < 8; i++) rd(i, "R1");

    // random traffic with short periods
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic [31:0] d;
      a = $urandom_range(0, 7);
      d = $urandom;
      if (a == 2) d = {d[31:16], 16'($urandom_range(0, 12))};
      if (a == 3 && $urandom_range(0, 9) != 0) d = {d[31:16], 16'h0};
      if ($urandom_range(0, 9) < 6) cyc(1'b0, 5'(a << 2) | 5'($urandom_range(0, 3)), 32'h0, "");
      else                          cyc(1'b1, 5'(a << 2), d, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule